// File: doc/BRIEF.md
# Flash Erase Status Flag Generator

This block models the status-read side of the controller that runs program and erase operations inside a NOR flash array. A one-cycle command interface starts a byte program, queues sector erases, pauses and restarts an erase, or abandons any operation. A read strobe carries a byte address whose upper bits name the sector. While nothing is running, a read returns the stored byte. While an operation runs, is paused, or has failed, a read returns a status byte instead. Software reads that byte twice and compares the two values to learn what the array is doing.

The status byte carries five flags. Bit 7 is the inverse of the expected data bit. Bit 6 is a toggle bit that flips on every status read while an operation is active. Bit 5 is a failure flag raised by a bounded pulse counter. Bit 3 shows whether the window for adding more sectors to an erase has closed. Bit 2 is a second toggle bit that flips only when the read addresses a sector in the erase set. Because the toggle state advances on each read strobe, the reads themselves change the block's state. The byte array, the erase timing and the program timing are simple parameterised stand-ins for the real cells.

Top module: `flash_status_unit`

## Requirements
- R1: After hardware reset every array byte reads 0xFF, `rd_data` is 0x00 and both toggle states are 0. With no operation active, a read returns the byte at `rd_addr`, and the toggle states do not change.
- R2: `cmd_op`=1 (program) with `cmd_valid` writes `cmd_data` to a blank (0xFF) byte at `cmd_addr` after PROG_CYC cycles. Until then, status reads give bit 7 = NOT `cmd_data[7]`, bit 2 = 1, and bits 5 and 3 = 0. Status byte layout is {b7,b6,b5,0,b3,b2,0,0}.
- R3: Bit 6 flips on each status read while a program, an erase window, a running erase, a program during suspend, or a failure is active. Its value is the new toggle state.
- R4: During an erase, bit 2 flips on each read whose sector (`rd_addr` upper SECT_W bits) is in the erase set, and reads 1 for any other sector. Bit 7 is 0 during an erase.
- R5: `cmd_op`=2 (sector erase) from idle opens a window of WIN_CYC cycles in which bit 3 reads 0. Each sector erase command inside the window adds its sector and restarts the window. When the window closes, bit 3 reads 1.
- R6: Once the window has closed, sector erase commands are ignored. Sectors are erased in ascending order, ERASE_CYC cycles each, and every byte of an erased sector becomes 0xFF. The block returns to idle when the set is empty.
- R7: `cmd_op`=3 (suspend) pauses a running erase. A read of a suspended sector then gives bit 7 = 1, bit 6 unchanged, bit 3 = 1 and bit 2 toggling. A read of any other sector returns array data. `cmd_op`=4 (resume) continues the erase where it stopped.
- R8: A program command during suspend, aimed at a sector outside the erase set, runs a program. Reads of non-suspended sectors then show bit 3 = 1 and bit 2 = 1. Reads of suspended sectors toggle bit 2. Both kinds of read toggle bit 6. When the program ends, the erase is suspended again.
- R9: A program aimed at a non-blank byte reaches PULSE_LIM pulses and fails. Bit 5 then reads 1, bit 6 keeps toggling, the byte is unchanged, and every command except reset is ignored.
- R10: `cmd_op`=5 (reset) returns the block to idle from any state, empties the erase set and leaves sectors that were not yet erased unchanged.
- R11: A read happens only on a rising edge of `rd_stb`. `rd_data` is updated at the clock edge that first samples the strobe high. Holding the strobe high counts as one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 program, 2 sector erase, 3 suspend, 4 resume, 5 reset |
| cmd_addr | input | SECT_W+WORD_W | Target byte address (sector in upper bits) |
| cmd_data | input | 8 | Program data |
| rd_stb | input | 1 | Read strobe, rising edge starts a read |
| rd_addr | input | SECT_W+WORD_W | Read address |
| rd_data | output | 8 | Array byte or status byte |

## Verification
If the phase or erase-set tracking is wrong, the next read shows it. Bit 6 or bit 2 comes back with the wrong parity, or an array byte appears where a status byte was due. The bench therefore keeps its own copies of both toggle states and checks every read. Timer faults appear as bit 3 or bit 5 arriving early or late. Erase-order faults appear as bit 2 still toggling for a sector that should already be finished. The final content of each sector is read back once the block is idle.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_ERASE  = 3'd2;
  localparam logic [2:0] OP_SUSP   = 3'd3;
  localparam logic [2:0] OP_RESUME = 3'd4;
  localparam logic [2:0] OP_RESET  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_WIN   = 3'd2,
    ST_RUN   = 3'd3,
    ST_SUSP  = 3'd4,
    ST_SPROG = 3'd5,
    ST_FAIL  = 3'd6
  } fsu_st_e;

  // status byte assembly: unused positions stay 0
  function automatic logic [7:0] pack_status(input logic inv7, input logic tg6,
                                             input logic fail5, input logic tmr3,
                                             input logic tg2);
    pack_status = {inv7, tg6, fail5, 1'b0, tmr3, tg2, 2'b00};
  endfunction

  // a counter has reached its last cycle
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    at_last = (cnt == len - 1);
  endfunction

endpackage

// File: rtl/fsu_seq.sv
module fsu_seq
  import fsu_pkg::*;
#(
  parameter int SECT_W    = 3,
  parameter int WORD_W    = 2,
  parameter int WIN_CYC   = 40,
  parameter int ERASE_CYC = 60,
  parameter int PROG_CYC  = 40,
  parameter int PULSE_LIM = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [SECT_W+WORD_W-1:0] cmd_addr,
  input  logic [7:0]               cmd_data,
  input  logic                     tgt_blank,
  output fsu_st_e                  st,
  output logic [(1<<SECT_W)-1:0]   mask,
  output logic                     pd7,
  output logic                     prog_we,
  output logic [SECT_W+WORD_W-1:0] prog_addr,
  output logic [7:0]               prog_data,
  output logic                     erase_we,
  output logic [SECT_W-1:0]        erase_sect
);

  localparam int ADDR_W = SECT_W + WORD_W;
  localparam int N_SECT = 1 << SECT_W;
  localparam int PCNT_W = $clog2(PULSE_LIM + 1);
  localparam int WCNT_W = $clog2(WIN_CYC + 1);
  localparam int ECNT_W = $clog2(ERASE_CYC + 1);

  function automatic logic [N_SECT-1:0] sect_bit(input logic [SECT_W-1:0] s);
    sect_bit = N_SECT'(1) << s;
  endfunction

  function automatic logic [SECT_W-1:0] lowest_set(input logic [N_SECT-1:0] m);
    lowest_set = '0;
    for (int i = N_SECT - 1; i >= 0; i--)
      if (m[i]) lowest_set = SECT_W'(i);
  endfunction

  logic [PCNT_W-1:0] pcnt;
  logic [WCNT_W-1:0] wcnt;
  logic [ECNT_W-1:0] ecnt;
  logic              nonblank;

  // named internal events
  logic              reset_cmd, prog_cmd, erase_cmd, susp_cmd, resume_cmd;
  logic              in_prog, prog_hit, fail_hit, win_expire, sect_done;
  logic [SECT_W-1:0] cmd_sect, cur_sect;
  logic [N_SECT-1:0] mask_clr;

  assign cmd_sect   = cmd_addr[ADDR_W-1 -: SECT_W];
  assign reset_cmd  = cmd_valid && (cmd_op == OP_RESET);
  assign prog_cmd   = cmd_valid && (cmd_op == OP_PROG);
  assign erase_cmd  = cmd_valid && (cmd_op == OP_ERASE);
  assign susp_cmd   = cmd_valid && (cmd_op == OP_SUSP);
  assign resume_cmd = cmd_valid && (cmd_op == OP_RESUME);

  assign in_prog    = (st == ST_PROG) || (st == ST_SPROG);
  assign prog_hit   = in_prog && !nonblank && at_last(pcnt, PROG_CYC) && !reset_cmd;
  assign fail_hit   = in_prog && nonblank && at_last(pcnt, PULSE_LIM);
  assign win_expire = (st == ST_WIN) && at_last(wcnt, WIN_CYC) && !erase_cmd;
  assign sect_done  = (st == ST_RUN) && at_last(ecnt, ERASE_CYC) && !reset_cmd;
  assign cur_sect   = lowest_set(mask);
  assign mask_clr   = mask & ~sect_bit(cur_sect);

  assign pd7        = prog_data[7];
  assign prog_we    = prog_hit;
  assign erase_we   = sect_done;
  assign erase_sect = cur_sect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      mask      <= '0;
      pcnt      <= '0;
      wcnt      <= '0;
      ecnt      <= '0;
      nonblank  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else if (reset_cmd) begin
      st       <= ST_IDLE;
      mask     <= '0;
      pcnt     <= '0;
      wcnt     <= '0;
      ecnt     <= '0;
      nonblank <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (prog_cmd) begin
            st        <= ST_PROG;
            pcnt      <= '0;
            nonblank  <= !tgt_blank;
            prog_addr <= cmd_addr;
            prog_data <= cmd_data;
          end else if (erase_cmd) begin
            st   <= ST_WIN;
            mask <= sect_bit(cmd_sect);
            wcnt <= '0;
          end
        end
        ST_PROG, ST_SPROG: begin
          if (fail_hit)      st <= ST_FAIL;
          else if (prog_hit) st <= (st == ST_PROG) ? ST_IDLE : ST_SUSP;
          else               pcnt <= pcnt + 1'b1;
        end
        ST_WIN: begin
          if (erase_cmd) begin
            mask <= mask | sect_bit(cmd_sect);
            wcnt <= '0;
          end else if (win_expire) begin
            st   <= ST_RUN;
            ecnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (sect_done) begin
            mask <= mask_clr;
            ecnt <= '0;
            if (mask_clr == '0) st <= ST_IDLE;
            else if (susp_cmd)  st <= ST_SUSP;
          end else begin
            ecnt <= ecnt + 1'b1;
            if (susp_cmd) st <= ST_SUSP;
          end
        end
        ST_SUSP: begin
          if (resume_cmd) begin
            st <= ST_RUN;
          end else if (prog_cmd && !mask[cmd_sect]) begin
            st        <= ST_SPROG;
            pcnt      <= '0;
            nonblank  <= !tgt_blank;
            prog_addr <= cmd_addr;
            prog_data <= cmd_data;
          end
        end
        ST_FAIL: st <= ST_FAIL;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PCNT_W'(PULSE_LIM)); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAIL && !reset_cmd) |=> (st == ST_FAIL)); // R9
  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt < WCNT_W'(WIN_CYC)); // R5
  AST_ERASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt < ECNT_W'(ERASE_CYC)); // R6
  AST_RUN_NO_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |=> ((mask & ~$past(mask)) == '0)); // R6
  AST_SET_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN || st == ST_RUN || st == ST_SUSP || st == ST_SPROG) |-> (mask != '0)); // R6
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> (st == ST_IDLE && mask == '0)); // R10

endmodule

// File: rtl/fsu_array.sv
module fsu_array #(
  parameter int SECT_W = 3,
  parameter int WORD_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_we,
  input  logic [SECT_W+WORD_W-1:0] prog_addr,
  input  logic [7:0]               prog_data,
  input  logic                     erase_we,
  input  logic [SECT_W-1:0]        erase_sect,
  input  logic [SECT_W+WORD_W-1:0] rd_addr,
  input  logic [SECT_W+WORD_W-1:0] cmd_addr,
  output logic [7:0]               rd_q,
  output logic                     tgt_blank
);

  localparam int ADDR_W  = SECT_W + WORD_W;
  localparam int N_WORDS = 1 << ADDR_W;

  logic [7:0] mem [N_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (erase_we && (SECT_W'(i >> WORD_W) == erase_sect))
          mem[i] <= 8'hFF;
        else if (prog_we && (ADDR_W'(i) == prog_addr))
          mem[i] <= prog_data;
      end
    end
  end

  assign rd_q      = mem[rd_addr];
  assign tgt_blank = (mem[cmd_addr] == 8'hFF);

  AST_SECT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> (mem[{$past(erase_sect), WORD_W'(0)}] == 8'hFF)); // R6

endmodule

// File: rtl/fsu_readout.sv
module fsu_readout
  import fsu_pkg::*;
#(
  parameter int SECT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  fsu_st_e                st,
  input  logic [(1<<SECT_W)-1:0] mask,
  input  logic                   pd7,
  input  logic                   rd_stb,
  input  logic [SECT_W-1:0]      rd_sect,
  input  logic [7:0]             arr_q,
  output logic [7:0]             rd_data
);

  logic stb_q, tog6, tog2;
  logic rd_rise, in_set;
  logic f6, f2, use_arr, b7, b5, b3;
  logic t6n, t2n;
  logic [7:0] status;

  assign rd_rise = rd_stb && !stb_q;
  assign in_set  = mask[rd_sect];

  always_comb begin
    f6 = 1'b0; f2 = 1'b0; use_arr = 1'b0;
    b7 = 1'b0; b5 = 1'b0; b3 = 1'b0;
    case (st)
      ST_IDLE: use_arr = 1'b1;
      ST_PROG: begin
        b7 = !pd7; f6 = 1'b1;
      end
      ST_SPROG: begin
        b7 = !pd7; f6 = 1'b1; b3 = 1'b1; f2 = in_set;
      end
      ST_WIN: begin
        f6 = 1'b1; f2 = in_set;
      end
      ST_RUN: begin
        f6 = 1'b1; b3 = 1'b1; f2 = in_set;
      end
      ST_SUSP: begin
        use_arr = !in_set; b7 = 1'b1; b3 = 1'b1; f2 = in_set;
      end
      ST_FAIL: begin
        b7 = !pd7; f6 = 1'b1; b5 = 1'b1;
      end
      default: use_arr = 1'b1;
    endcase
  end

  assign t6n    = tog6 ^ f6;
  assign t2n    = tog2 ^ f2;
  assign status = pack_status(b7, t6n, b5, b3, f2 ? t2n : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      tog6    <= 1'b0;
      tog2    <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      stb_q <= rd_stb;
      if (rd_rise) begin
        tog6    <= t6n;
        tog2    <= t2n;
        rd_data <= use_arr ? arr_q : status;
      end
    end
  end

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rise |=> $stable(rd_data)); // R11
  AST_SUSP_T6_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && st == ST_SUSP) |=> $stable(tog6)); // R7
  AST_IDLE_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> ($stable(tog6) && $stable(tog2))); // R1

endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import fsu_pkg::*;
#(
  parameter int SECT_W    = 3,
  parameter int WORD_W    = 2,
  parameter int WIN_CYC   = 40,
  parameter int ERASE_CYC = 60,
  parameter int PROG_CYC  = 40,
  parameter int PULSE_LIM = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [SECT_W+WORD_W-1:0] cmd_addr,
  input  logic [7:0]               cmd_data,
  input  logic                     rd_stb,
  input  logic [SECT_W+WORD_W-1:0] rd_addr,
  output logic [7:0]               rd_data
);

  localparam int ADDR_W = SECT_W + WORD_W;
  localparam int N_SECT = 1 << SECT_W;

  fsu_st_e           st;
  logic [N_SECT-1:0] mask;
  logic              pd7, prog_we, erase_we, tgt_blank;
  logic [ADDR_W-1:0] prog_addr;
  logic [7:0]        prog_data, arr_q;
  logic [SECT_W-1:0] erase_sect;

  fsu_seq #(
    .SECT_W(SECT_W), .WORD_W(WORD_W), .WIN_CYC(WIN_CYC),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .PULSE_LIM(PULSE_LIM)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .tgt_blank(tgt_blank),
    .st(st), .mask(mask), .pd7(pd7), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_we(erase_we), .erase_sect(erase_sect)
  );

  fsu_array #(.SECT_W(SECT_W), .WORD_W(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_we(erase_we), .erase_sect(erase_sect),
    .rd_addr(rd_addr), .cmd_addr(cmd_addr), .rd_q(arr_q), .tgt_blank(tgt_blank)
  );

  fsu_readout #(.SECT_W(SECT_W)) u_readout (
    .clk(clk), .rst_n(rst_n), .st(st), .mask(mask), .pd7(pd7),
    .rd_stb(rd_stb), .rd_sect(rd_addr[ADDR_W-1 -: SECT_W]),
    .arr_q(arr_q), .rd_data(rd_data)
  );

endmodule

// File: tb/flash_status_unit_test.sv
module flash_status_unit_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] exp;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [4:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic       rd_stb = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;

  exp_t sb[$];
  int   tests = 0;
  int   fails = 0;
  logic t6 = 1'b0;
  logic t2 = 1'b0;
  bit   finished = 1'b0;

  flash_status_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] sbyte(input logic a7, input logic a6, input logic a5,
                                       input logic a3, input logic a2);
    logic [7:0] v;
    v = 8'h00;
    v[7] = a7; v[6] = a6; v[5] = a5; v[3] = a3; v[2] = a2;
    return v;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  // driver: push the expected byte, then strobe
  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string req,
                    input int hold = 1);
    exp_t e;
    @(negedge clk);
    e.exp = exp; e.req = req;
    sb.push_back(e);
    rd_addr = a; rd_stb = 1'b1;
    repeat (hold) @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // status read: m6 / m2 = 1 means that toggle advances on this read
  task automatic srd(input logic [4:0] a, input logic s7, input logic m6, input logic s5,
                     input logic s3, input logic m2, input string req, input int hold = 1);
    if (m6) t6 = ~t6;
    if (m2) t2 = ~t2;
    rd(a, sbyte(s7, t6, s5, s3, m2 ? t2 : 1'b1), req, hold);
  endtask

  // monitor: one comparison per rising strobe
  initial begin
    logic prev, cur;
    exp_t e;
    prev = 1'b0;
    forever begin
      @(posedge clk);
      cur = rd_stb;
      if (rst_n && cur && !prev) begin
        prev = cur;
        @(negedge clk);
        if (sb.size() == 0) begin
          tests++; fails++;
          $display("FAIL R11: unexpected read result %02h expected none", rd_data);
        end else begin
          e = sb.pop_front();
          check(rd_data, e.exp, e.req);
        end
      end else begin
        prev = cur;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(rd_data, 8'h00, "R1 reset value");
    rd(5'd0, 8'hFF, "R1 erased array");
    rd(5'd5, 8'hFF, "R1 erased array");

    // R2 / R3: program with status reads
    cmd(3'd1, 5'd5, 8'h3C);
    srd(5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R3 program status");
    srd(5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 toggle");
    srd(5'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R3 toggle");
    tick(50);
    rd(5'd5, 8'h3C, "R2 programmed");
    cmd(3'd1, 5'd13, 8'h00); tick(50);
    cmd(3'd1, 5'd17, 8'h11); tick(50);
    cmd(3'd1, 5'd25, 8'h77); tick(50);
    rd(5'd13, 8'h00, "R2 programmed");

    // R5 / R4: window with added sector
    cmd(3'd2, 5'd12, 8'h00);
    srd(5'd12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 window open");
    tick(10);
    cmd(3'd2, 5'd16, 8'h00);
    srd(5'd16, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R4 added sector toggles");
    srd(5'd5,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 other sector reads 1");
    tick(26);
    srd(5'd12, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 window restarted");
    tick(12);
    srd(5'd12, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R5 window closed");
    cmd(3'd2, 5'd24, 8'h00);  // sector 6, ignored (R6)

    // R7 / R8: suspend and program in suspend
    cmd(3'd3, 5'd0, 8'h00);
    srd(5'd12, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R7 suspended sector");
    rd(5'd5, 8'h3C, "R7 other sector array data");
    rd(5'd25, 8'h77, "R6 R7 late sector not in set");
    cmd(3'd1, 5'd8, 8'h5A);
    srd(5'd9,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R8 non-suspended reads 1");
    srd(5'd16, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R8 suspended sector toggles");
    tick(45);
    rd(5'd8, 8'h5A, "R8 program done, back in suspend");
    cmd(3'd4, 5'd0, 8'h00);
    tick(60);
    srd(5'd13, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 lower sector done first");
    srd(5'd17, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R6 higher sector pending");
    tick(70);
    rd(5'd13, 8'hFF, "R6 sector erased");
    rd(5'd17, 8'hFF, "R6 sector erased");
    rd(5'd25, 8'h77, "R6 ignored sector intact");
    rd(5'd5,  8'h3C, "R6 other sector intact");

    // R9: non-blank program fails
    cmd(3'd1, 5'd5, 8'h01);
    srd(5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 before limit");
    tick(210);
    srd(5'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 failure flag");
    cmd(3'd2, 5'd0, 8'h00);
    srd(5'd5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 failure sticky");
    cmd(3'd5, 5'd0, 8'h00);
    rd(5'd5, 8'h3C, "R9 R10 byte unchanged after reset");

    // R10: reset abandons a running erase
    cmd(3'd2, 5'd4, 8'h00);
    tick(60);
    cmd(3'd5, 5'd0, 8'h00);
    rd(5'd5, 8'h3C, "R10 erase abandoned");
    cmd(3'd1, 5'd4, 8'hE7);
    srd(5'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 idle accepts program");
    tick(50);
    rd(5'd4, 8'hE7, "R2 second program");

    // R11: held strobe is one read
    cmd(3'd1, 5'd6, 8'h42);
    srd(5'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 held strobe", 4);
    srd(5'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 single toggle per strobe");
    tick(50);
    rd(5'd6, 8'h42, "R11 held idle read", 3);

    tick(5);
    tests++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d reads missing expected 0", sb.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule